// File: doc/BRIEF.md
# Segment Translation Unit with Descriptor Cache

This block turns a segmented logical address (a register number plus a 32-bit offset) into a 32-bit linear address. It holds six segment registers. Each register keeps a 16-bit selector and a hidden cache of the descriptor that the selector names. When software loads a selector, the block reads the 8-byte descriptor from one of two descriptor tables in memory. It uses two 32-bit reads on a simple read port, checks the descriptor, and on success stores its base and its scaled limit in the register's cache.

Translations use only the cached values, so they never touch memory. The linear address is the cached base plus the offset. It is produced combinationally in the same cycle as the request, together with a fault flag for an offset beyond the limit. Load faults cover an absent descriptor and insufficient privilege. A faulting load leaves the cache untouched. Register 1 is the code register, and its selector's low two bits are the current privilege level.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every register translates as a flat segment: base 0, limit 0xFFFFFFFF, so any offset maps to itself without fault. The current privilege level is 0, and busy, ld_done and ld_fault are low.
- R2: An accepted load reads the descriptor at table_base + 8*index, then at that address + 4. Selector bits 15:3 are the index, and bit 2 picks the table (0 = gdt_base, 1 = ldt_base). mem_addr holds steady while mem_req waits for mem_rvalid. busy stays high from the cycle after acceptance until the cycle ld_done pulses.
- R3: Descriptor layout. First word: bits 15:0 are limit[15:0] and bits 31:16 are base[15:0]. Second word: bits 7:0 are base[23:16], bits 14:13 are DPL, bit 15 is present, bits 19:16 are limit[19:16], bit 23 is granularity, and bits 31:24 are base[31:24].
- R4: A translation request (xl_valid) on register r with offset o yields xl_lin = base_r + o (mod 2^32) with xl_ok high, in the same cycle.
- R5: With granularity 0 the effective limit is the 20-bit limit in bytes. An offset greater than the effective limit raises xl_fault.
- R6: With granularity 1 the effective limit is (limit << 12) | 0xFFF.
- R7: A descriptor with present = 0 ends the load with ld_fault high and ld_fault_code = 2, and leaves the register's cache and selector unchanged.
- R8: A load into any register other than register 1 faults with code 1 when max(CPL, RPL) > DPL, and the cache is unchanged. When a descriptor is both absent and too privileged, code 2 is reported.
- R9: A successful load into register 1 skips the privilege check and sets the current privilege level to the loaded selector's bits 1:0. The level changes only with a successful load.
- R10: A load request while busy is high, or one naming a register number of 6 or more, is ignored: no fetch, no ld_done, no cache change.
- R11: A translation naming register 6 or 7 faults. Any translation fault forces xl_ok low and xl_lin to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gdt_base | input | 32 | Byte address of the global descriptor table |
| ldt_base | input | 32 | Byte address of the local descriptor table |
| ld_valid | input | 1 | Selector load request |
| ld_reg | input | 3 | Target segment register number |
| ld_sel | input | 16 | Selector to load |
| busy | output | 1 | Descriptor fetch in progress |
| ld_done | output | 1 | One-cycle pulse at the end of a load |
| ld_fault | output | 1 | The finishing load faulted (valid with ld_done) |
| ld_fault_code | output | 2 | 0 none, 1 privilege, 2 not present |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Read data valid; completes the current read |
| mem_rdata | input | 32 | Read data |
| xl_valid | input | 1 | Translation request |
| xl_reg | input | 3 | Segment register used for translation |
| xl_offset | input | 32 | Offset within the segment |
| xl_ok | output | 1 | Translation succeeded |
| xl_fault | output | 1 | Translation faulted |
| xl_lin | output | 32 | Linear address (0 on fault) |
| cpl | output | 2 | Current privilege level |

## Verification
The hardest state to reach is a privilege fault that depends on an earlier load. The outcome depends on the CPL left behind by a previous load of the code register, so the bench first loads register 1 with each RPL and then sweeps data-register loads over every RPL and DPL against that level. A second corner is a load request arriving while a fetch waits on a stalled read. The bench holds mem_rvalid low to keep the block busy, pushes in a competing request, and then confirms through translations that only the first register changed.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   // Contents of one hidden descriptor cache entry
   typedef struct packed {
      logic [31:0] base;
      logic [31:0] lim;   // already scaled by granularity
      logic [15:0] sel;
   } seg_entry_t;

   typedef enum logic [1:0] {
      LF_NONE = 2'd0,
      LF_PRIV = 2'd1,
      LF_NP   = 2'd2
   } ld_fault_e;

   typedef enum logic [1:0] {
      FS_IDLE,
      FS_RD_LO,
      FS_RD_HI,
      FS_CHECK
   } fetch_state_e;

endpackage

// File: rtl/seg_limit_scale.sv
module seg_limit_scale #(
   parameter int AW         = 32,
   parameter int LIMIT_W    = 20,
   parameter int GRAN_SHIFT = 12
) (
   input  logic [LIMIT_W-1:0] raw_lim,
   input  logic               gran,
   output logic [AW-1:0]      eff_lim
);
   localparam int SCALED_W = LIMIT_W + GRAN_SHIFT;

   generate
      if (SCALED_W == AW) begin : g_exact
         assign eff_lim = gran ? {raw_lim, {GRAN_SHIFT{1'b1}}} : AW'(raw_lim);
      end else begin : g_bad_width
         $error("seg_limit_scale: LIMIT_W + GRAN_SHIFT must equal AW");
         assign eff_lim = '0;
      end
   endgenerate

endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
   import seg_xlate_pkg::*;
#(
   parameter int AW = 32,
   parameter int RW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [RW-1:0] start_reg,
   input  logic [15:0]   start_sel,
   input  logic [AW-1:0] gdt_base,
   input  logic [AW-1:0] ldt_base,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_rvalid,
   input  logic [31:0]   mem_rdata,
   output logic          busy,
   output logic          desc_valid,
   output logic [RW-1:0] tgt_reg,
   output logic [15:0]   tgt_sel,
   output logic [31:0]   desc_lo,
   output logic [31:0]   desc_hi
);
   localparam int DESC_SHIFT = 3;          // 8 bytes per descriptor
   localparam int WORD_BYTES = 4;

   fetch_state_e  state_q;
   logic [AW-1:0] addr_q;
   logic [31:0]   lo_q, hi_q;
   logic [RW-1:0] reg_q;
   logic [15:0]   sel_q;
   logic [AW-1:0] tbl_base;

   assign tbl_base = start_sel[2] ? ldt_base : gdt_base;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         addr_q  <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
         reg_q   <= '0;
         sel_q   <= '0;
      end else begin
         case (state_q)
            FS_IDLE: if (start) begin
               reg_q   <= start_reg;
               sel_q   <= start_sel;
               addr_q  <= tbl_base + AW'({start_sel[15:3], {DESC_SHIFT{1'b0}}});
               state_q <= FS_RD_LO;
            end
            FS_RD_LO: if (mem_rvalid) begin
               lo_q    <= mem_rdata;
               addr_q  <= addr_q + AW'(WORD_BYTES);
               state_q <= FS_RD_HI;
            end
            FS_RD_HI: if (mem_rvalid) begin
               hi_q    <= mem_rdata;
               state_q <= FS_CHECK;
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   assign mem_req    = (state_q == FS_RD_LO) || (state_q == FS_RD_HI);
   assign mem_addr   = addr_q;
   assign busy       = (state_q != FS_IDLE);
   assign desc_valid = (state_q == FS_CHECK);
   assign tgt_reg    = reg_q;
   assign tgt_sel    = sel_q;
   assign desc_lo    = lo_q;
   assign desc_hi    = hi_q;

endmodule

// File: rtl/seg_cache_bank.sv
module seg_cache_bank
   import seg_xlate_pkg::*;
#(
   parameter int NUM_SEGS = 6,
   parameter int CODE_SEG = 1,
   parameter int RW       = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [RW-1:0] wr_idx,
   input  seg_entry_t    wr_ent,
   input  logic [RW-1:0] rd_idx,
   output seg_entry_t    rd_ent,
   output logic          rd_hit,
   output logic [1:0]    cpl
);
   seg_entry_t ents [NUM_SEGS];

   genvar g;
   generate
      for (g = 0; g < NUM_SEGS; g++) begin : g_seg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ents[g].base <= '0;
               ents[g].lim  <= '1;
               ents[g].sel  <= '0;
            end else if (wr_en && (wr_idx == RW'(g))) begin
               ents[g] <= wr_ent;
            end
         end
      end
   endgenerate

   always_comb begin
      rd_ent = '0;
      rd_hit = 1'b0;
      for (int i = 0; i < NUM_SEGS; i++) begin
         if (rd_idx == RW'(i)) begin
            rd_ent = ents[i];
            rd_hit = 1'b1;
         end
      end
   end

   assign cpl = ents[CODE_SEG].sel[1:0];

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int NUM_SEGS   = 6,
   parameter int CODE_SEG   = 1,
   parameter int AW         = 32,
   parameter int LIMIT_W    = 20,
   parameter int GRAN_SHIFT = 12,
   localparam int RW        = $clog2(NUM_SEGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] gdt_base,
   input  logic [AW-1:0] ldt_base,
   input  logic          ld_valid,
   input  logic [RW-1:0] ld_reg,
   input  logic [15:0]   ld_sel,
   output logic          busy,
   output logic          ld_done,
   output logic          ld_fault,
   output logic [1:0]    ld_fault_code,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_rvalid,
   input  logic [31:0]   mem_rdata,
   input  logic          xl_valid,
   input  logic [RW-1:0] xl_reg,
   input  logic [AW-1:0] xl_offset,
   output logic          xl_ok,
   output logic          xl_fault,
   output logic [AW-1:0] xl_lin,
   output logic [1:0]    cpl
);
   generate
      if (CODE_SEG >= NUM_SEGS) begin : g_bad_code
         $error("seg_xlate_unit: CODE_SEG out of range");
      end
      if (AW != 32) begin : g_bad_aw
         $error("seg_xlate_unit: descriptor base is 32 bits wide");
      end
   endgenerate

   // ---------------- descriptor fetch ----------------
   logic          start;
   logic          desc_valid;
   logic [RW-1:0] tgt_reg;
   logic [15:0]   tgt_sel;
   logic [31:0]   desc_lo, desc_hi;

   assign start = ld_valid && !busy && (ld_reg < RW'(NUM_SEGS));

   seg_desc_fetch #(.AW(AW), .RW(RW)) u_fetch (
      .clk(clk), .rst_n(rst_n), .start(start), .start_reg(ld_reg),
      .start_sel(ld_sel), .gdt_base(gdt_base), .ldt_base(ldt_base),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .busy(busy), .desc_valid(desc_valid),
      .tgt_reg(tgt_reg), .tgt_sel(tgt_sel), .desc_lo(desc_lo), .desc_hi(desc_hi)
   );

   // ---------------- descriptor decode ----------------
   logic [31:0]        d_base;
   logic [LIMIT_W-1:0] d_lim;
   logic               d_gran, d_present;
   logic [1:0]         d_dpl;
   logic [AW-1:0]      d_eff_lim;

   assign d_base    = {desc_hi[31:24], desc_hi[7:0], desc_lo[31:16]};
   assign d_lim     = LIMIT_W'({desc_hi[19:16], desc_lo[15:0]});
   assign d_gran    = desc_hi[23];
   assign d_present = desc_hi[15];
   assign d_dpl     = desc_hi[14:13];

   seg_limit_scale #(.AW(AW), .LIMIT_W(LIMIT_W), .GRAN_SHIFT(GRAN_SHIFT)) u_scale (
      .raw_lim(d_lim), .gran(d_gran), .eff_lim(d_eff_lim)
   );

   // ---------------- load checks ----------------
   logic [1:0] rpl, eff_pl;
   logic       np_flt, priv_flt, commit;
   seg_entry_t new_ent;

   assign rpl      = tgt_sel[1:0];
   assign eff_pl   = (cpl > rpl) ? cpl : rpl;
   assign np_flt   = !d_present;
   assign priv_flt = (tgt_reg != RW'(CODE_SEG)) && (eff_pl > d_dpl);
   assign commit   = desc_valid && !np_flt && !priv_flt;

   assign new_ent.base = d_base;
   assign new_ent.lim  = d_eff_lim;
   assign new_ent.sel  = tgt_sel;

   ld_fault_e code_d;
   always_comb begin
      code_d = LF_NONE;
      if (desc_valid) begin
         if (np_flt)        code_d = LF_NP;
         else if (priv_flt) code_d = LF_PRIV;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_done       <= 1'b0;
         ld_fault      <= 1'b0;
         ld_fault_code <= LF_NONE;
      end else begin
         ld_done       <= desc_valid;
         ld_fault      <= desc_valid && (np_flt || priv_flt);
         ld_fault_code <= code_d;
      end
   end

   // ---------------- cache and translation ----------------
   seg_entry_t rd_ent;
   logic       rd_hit;

   seg_cache_bank #(.NUM_SEGS(NUM_SEGS), .CODE_SEG(CODE_SEG), .RW(RW)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_idx(tgt_reg),
      .wr_ent(new_ent), .rd_idx(xl_reg), .rd_ent(rd_ent), .rd_hit(rd_hit),
      .cpl(cpl)
   );

   logic xl_bad;
   assign xl_bad   = !rd_hit || (xl_offset > rd_ent.lim);
   assign xl_fault = xl_valid && xl_bad;
   assign xl_ok    = xl_valid && !xl_bad;
   assign xl_lin   = xl_ok ? (rd_ent.base + xl_offset) : '0;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        mem_req,
   input logic [31:0] mem_addr,
   input logic        mem_rvalid,
   input logic        ld_done,
   input logic        ld_fault,
   input logic        xl_valid,
   input logic        xl_ok,
   input logic        xl_fault,
   input logic [31:0] xl_lin,
   input logic [1:0]  cpl
);
   // R2
   req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_done |-> !busy);

   // R7
   fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_fault |-> ld_done);

   // R11
   fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xl_fault |-> (!xl_ok && (xl_lin == 32'd0)));

   // R9
   cpl_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cpl) |-> (ld_done && !ld_fault));

   // R4
   idle_xl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xl_valid |-> (!xl_ok && !xl_fault));

endmodule

bind seg_xlate_unit seg_xlate_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req),
   .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .ld_done(ld_done),
   .ld_fault(ld_fault), .xl_valid(xl_valid), .xl_ok(xl_ok),
   .xl_fault(xl_fault), .xl_lin(xl_lin), .cpl(cpl)
);

// File: tb/tb_seg_xlate_unit.sv
`timescale 1ns/1ps
module tb_seg_xlate_unit;
   localparam logic [31:0] GDT = 32'h0000_1000;
   localparam logic [31:0] LDT = 32'h0000_1080;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_valid = 1'b0;
   logic [2:0]  ld_reg = '0;
   logic [15:0] ld_sel = '0;
   logic        busy, ld_done, ld_fault;
   logic [1:0]  ld_fault_code;
   logic        mem_req, mem_rvalid;
   logic [31:0] mem_addr, mem_rdata;
   logic        xl_valid = 1'b0;
   logic [2:0]  xl_reg = '0;
   logic [31:0] xl_offset = '0;
   logic        xl_ok, xl_fault;
   logic [31:0] xl_lin;
   logic [1:0]  cpl;
   logic        stall = 1'b0;

   always #4 clk = ~clk;

   seg_xlate_unit dut (
      .clk(clk), .rst_n(rst_n), .gdt_base(GDT), .ldt_base(LDT),
      .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_sel(ld_sel), .busy(busy),
      .ld_done(ld_done), .ld_fault(ld_fault), .ld_fault_code(ld_fault_code),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .xl_valid(xl_valid), .xl_reg(xl_reg),
      .xl_offset(xl_offset), .xl_ok(xl_ok), .xl_fault(xl_fault),
      .xl_lin(xl_lin), .cpl(cpl)
   );

   // memory model: two tables of 16 descriptors, one-cycle reads
   logic [31:0] mem [0:63];
   logic [31:0] moff;
   assign moff       = mem_addr - GDT;
   assign mem_rvalid = mem_req && !stall;
   assign mem_rdata  = (moff < 32'd256) ? mem[moff[7:2]] : 32'hDEAD_BEEF;

   int          cap_n = 0;
   logic [31:0] cap_prev, cap_last;
   always @(posedge clk) if (mem_req && mem_rvalid) begin
      cap_prev <= cap_last;
      cap_last <= mem_addr;
      cap_n    <= cap_n + 1;
   end

   // descriptor model
   logic [31:0] d_base [0:31];
   logic [19:0] d_lim  [0:31];
   logic        d_g    [0:31];
   logic [1:0]  d_dpl  [0:31];
   logic        d_p    [0:31];
   // cache model
   logic [31:0] m_base [0:5];
   logic [31:0] m_lim  [0:5];
   logic [1:0]  m_cpl;

   int n_tests = 0;
   int n_fail  = 0;

   task automatic check(input bit good, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] eff_lim(input logic [19:0] l, input logic g);
      return g ? {l, 12'hFFF} : {12'h000, l};
   endfunction

   task automatic set_desc(input int t, input int i, input logic [31:0] b,
                           input logic [19:0] l, input logic g,
                           input logic [1:0] dpl, input logic p);
      int k = t*16 + i;
      mem[k*2]     = {b[15:0], l[15:0]};
      mem[k*2 + 1] = {b[31:24], g, 3'b100, l[19:16], p, dpl, 1'b1, 4'h2, b[23:16]};
      d_base[k] = b; d_lim[k] = l; d_g[k] = g; d_dpl[k] = dpl; d_p[k] = p;
   endtask

   task automatic xl(input int r, input logic [31:0] off, input string req);
      logic        eok;
      logic [31:0] elin;
      @(negedge clk);
      xl_valid = 1'b1; xl_reg = 3'(r); xl_offset = off;
      #1;
      if (r < 6) begin
         eok  = (off <= m_lim[r]);
         elin = eok ? m_base[r] + off : 32'd0;
      end else begin
         eok = 1'b0; elin = 32'd0;
      end
      check((xl_ok == eok) && (xl_fault == !eok) && (xl_lin == elin),
            req, $sformatf("translate reg %0d off %h", r, off), xl_lin, elin);
      xl_valid = 1'b0;
   endtask

   task automatic load(input int r, input int t, input int i, input logic [1:0] rpl,
                       input string req);
      int          k = t*16 + i;
      int          c0 = cap_n;
      int          n = 0;
      logic [1:0]  ecode;
      logic [1:0]  epl;
      logic [31:0] ea;
      epl = (m_cpl > rpl) ? m_cpl : rpl;
      if (!d_p[k])                    ecode = 2'd2;
      else if (r != 1 && epl > d_dpl[k]) ecode = 2'd1;
      else                            ecode = 2'd0;
      ea = (t == 1 ? LDT : GDT) + 32'(i*8);
      @(negedge clk);
      ld_valid = 1'b1; ld_reg = 3'(r); ld_sel = {13'(i), t[0], rpl};
      @(negedge clk);
      ld_valid = 1'b0;
      check(busy == 1'b1, "R2", "busy after accept", 32'(busy), 32'd1);
      while (!ld_done && n < 100) begin @(negedge clk); n++; end
      check(ld_done == 1'b1, "R2", "load finished", 32'(ld_done), 32'd1);
      check((ld_fault_code == ecode) && (ld_fault == (ecode != 0)), req,
            $sformatf("fault code reg %0d t%0d i%0d", r, t, i), 32'(ld_fault_code), 32'(ecode));
      check((cap_n - c0 == 2) && (cap_prev == ea) && (cap_last == ea + 32'd4), "R2",
            "fetch addresses", cap_prev, ea);
      if (ecode == 2'd0) begin
         m_base[r] = d_base[k];
         m_lim[r]  = eff_lim(d_lim[k], d_g[k]);
         if (r == 1) m_cpl = rpl;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int w = 0; w < 64; w++) mem[w] = 32'h0;
      for (int r = 0; r < 6; r++) begin m_base[r] = 32'h0; m_lim[r] = 32'hFFFF_FFFF; end
      m_cpl = 2'd0;
      for (int i = 0; i < 16; i++) begin
         set_desc(0, i, 32'h1000_0000 + 32'(i) * 32'h0123_4567, 20'(i*32'h111 + 3),
                  i[0], 2'd3, 1'b1);
         set_desc(1, i, 32'h8000_0000 - 32'(i) * 32'h0101_0101, 20'(32'h00FFF - i*7),
                  !i[0], 2'd3, 1'b1);
      end
      set_desc(0, 15, 32'h5555_0000, 20'h00100, 1'b0, 2'd0, 1'b0);

      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: flat after reset
      check((cpl == 0) && !busy && !ld_done && !ld_fault, "R1", "reset outputs",
            {28'h0, cpl, busy, ld_done}, 32'h0);
      for (int r = 0; r < 6; r++) begin
         xl(r, 32'h0, "R1");
         xl(r, 32'h1234_5678, "R1");
         xl(r, 32'hFFFF_FFFF, "R1");
      end
      // R11: registers beyond the bank
      xl(6, 32'h10, "R11");
      xl(7, 32'h0, "R11");

      // R10: load to a non-existent register is ignored
      @(negedge clk);
      ld_valid = 1'b1; ld_reg = 3'd7; ld_sel = 16'h0008;
      @(negedge clk);
      ld_valid = 1'b0;
      check(!busy && !mem_req, "R10", "reg 7 load ignored", {30'h0, busy, mem_req}, 32'h0);
      repeat (4) begin
         @(negedge clk);
         check(!ld_done, "R10", "no done for reg 7", 32'(ld_done), 32'h0);
      end

      // R3 R4 R5 R6: sweep both tables
      for (int t = 0; t < 2; t++) begin
         for (int i = 0; i < 14; i++) begin
            int r = i % 6;
            logic [31:0] e;
            load(r, t, i, (r == 1) ? 2'd0 : 2'(i), "R3");
            e = m_lim[r];
            xl(r, 32'h0, "R4");
            xl(r, 32'h7, "R4");
            xl(r, e, (d_g[t*16+i]) ? "R6" : "R5");
            if (e != 32'hFFFF_FFFF) xl(r, e + 32'd1, (d_g[t*16+i]) ? "R6" : "R5");
         end
      end

      // R7: absent descriptor, cache unchanged
      load(2, 0, 15, 2'd0, "R7");
      xl(2, 32'h0, "R7");
      xl(2, 32'h9, "R7");
      // R8: absent and too privileged at once reports not-present
      load(3, 0, 15, 2'd3, "R8");
      xl(3, 32'h5, "R8");

      // R8 R9: privilege sweep
      for (int c = 0; c < 4; c++) begin
         load(1, 0, 0, 2'(c), "R9");
         check(cpl == 2'(c), "R9", "cpl after code load", 32'(cpl), 32'(c));
         for (int rp = 0; rp < 4; rp++) begin
            for (int d = 0; d < 4; d++) begin
               set_desc(0, 14, 32'h0A00_0000 + 32'(c*16 + rp*4 + d) * 32'h100,
                        20'h00FFF, 1'b0, 2'(d), 1'b1);
               load(3, 0, 14, 2'(rp), "R8");
               xl(3, 32'h40, "R8");
            end
         end
      end
      // R9: code load ignores DPL and moves CPL
      set_desc(0, 14, 32'h0B00_0000, 20'h00FFF, 1'b0, 2'd0, 1'b1);
      load(1, 0, 14, 2'd3, "R9");
      check(cpl == 2'd3, "R9", "cpl from code rpl", 32'(cpl), 32'd3);
      load(1, 0, 1, 2'd0, "R9");
      check(cpl == 2'd0, "R9", "cpl back to 0", 32'(cpl), 32'd0);

      // R10 R2: stalled fetch, competing request ignored
      stall = 1'b1;
      @(negedge clk);
      ld_valid = 1'b1; ld_reg = 3'd4; ld_sel = {13'd3, 1'b0, 2'd0};
      @(negedge clk);
      ld_valid = 1'b1; ld_reg = 3'd5; ld_sel = {13'd5, 1'b1, 2'd0};
      check(busy && mem_req && (mem_addr == GDT + 32'd24), "R2", "stalled address",
            mem_addr, GDT + 32'd24);
      repeat (5) @(negedge clk);
      ld_valid = 1'b0;
      check(busy && (mem_addr == GDT + 32'd24), "R10", "still on first fetch",
            mem_addr, GDT + 32'd24);
      stall = 1'b0;
      begin
         int n = 0;
         while (!ld_done && n < 100) begin @(negedge clk); n++; end
      end
      check(ld_done && !ld_fault, "R10", "first load done", 32'(ld_done), 32'd1);
      m_base[4] = d_base[3]; m_lim[4] = eff_lim(d_lim[3], d_g[3]);
      repeat (4) begin
         @(negedge clk);
         check(!ld_done && !busy, "R10", "no second load", {30'h0, ld_done, busy}, 32'h0);
      end
      xl(4, 32'h2, "R10");
      xl(5, 32'h2, "R10");
      xl(5, m_lim[5], "R10");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule